// File: doc/BRIEF.md
# Decode-Stage Issue Interlock

This block makes the issue decision in the decode stage of a small in-order five-stage pipeline that has no operand forwarding. In every cycle it looks at the instruction in decode: its class, its two source register numbers and its destination register number. It also looks at the writeback port and the state of the decode-to-execute latch. From these it decides whether the instruction moves into execute in this cycle or stays in decode.

A 32-entry busy scoreboard records which registers have a result still in flight. A bit is set when a register-writing instruction issues, and it is cleared when that result is written back. Because nothing is forwarded, a reader waits for the producer's writeback. The register file writes in the first half of a cycle and is read in the second half, so a writeback in the current cycle releases a waiting reader in that same cycle.

A compare-and-branch instruction seen in decode freezes fetch. After it issues, no further instruction leaves decode until execute reports that the branch is resolved. The decoder, the register file, the ALU and the memories are outside this block.

Top module: `dec_interlock`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `busy_vec` is all zeros and `br_hold` is 0. This holds even if a branch was pending when reset was applied.
- R2: An instruction in decode (`dec_valid`=1) issues in the same cycle (`issue`=1) when all of the following hold: the decode-to-execute latch is empty, no branch is pending, and no source or destination conflict exists. Decode therefore costs one cycle for an instruction that is not stalled.
- R3: `issue` is never 1 while `idex_empty` is 0. An instruction held for that reason alone raises `dec_hold` but not `data_stall`.
- R4: The class codes on `dec_cls` are add=0, sub=1, addi=2, mul=3, lw=4, sw=5, beq=6 and no-op=7. Every class except no-op reads `dec_rs`. Classes add, sub, mul, sw and beq also read `dec_rt`. Only classes 0 to 4 write `dec_dst`, and a no-op reads and writes nothing.
- R5: When a source register that the class reads is marked busy, `data_stall`=1 and `issue`=0. This lasts until that register is written back.
- R6: A writeback (`wb_valid`=1, `wb_reg`) in the current cycle removes a conflict on that register in that same cycle.
- R7: Issuing a class 0 to 4 instruction with a nonzero `dec_dst` sets that bit of `busy_vec` from the next cycle. A writeback clears its bit from the next cycle. If both hit the same register in one cycle, the bit stays set.
- R8: Register 0 is never marked busy and never causes a stall.
- R9: A writing instruction whose destination is already busy, and is not being written back in this cycle, stalls with `data_stall`=1.
- R10: After a beq issues, `br_hold`=1 from the next cycle until the cycle after `br_resolved` is seen. No instruction issues while `br_hold`=1.
- R11: `fetch_freeze`=1 whenever `br_hold`=1 or a valid beq is in decode. `dec_hold`=1 whenever `br_hold`=1 or a valid instruction does not issue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dec_valid | input | 1 | Decode latch holds an instruction |
| dec_cls | input | 3 | Instruction class code |
| dec_rs | input | 5 | First source register |
| dec_rt | input | 5 | Second source register |
| dec_dst | input | 5 | Destination register |
| idex_empty | input | 1 | Decode-to-execute latch can accept |
| wb_valid | input | 1 | A register write happens this cycle |
| wb_reg | input | 5 | Register written this cycle |
| br_resolved | input | 1 | Execute has resolved the pending branch |
| issue | output | 1 | Instruction moves to execute at this edge |
| data_stall | output | 1 | Held by a register conflict |
| br_hold | output | 1 | A branch is unresolved |
| fetch_freeze | output | 1 | Fetch must not advance |
| dec_hold | output | 1 | Decode latch must keep its contents |
| busy_vec | output | 32 | Scoreboard of pending writes |

## Verification
The bound checker watches several rules on every cycle. It confirms that nothing issues into a full latch or during a branch hold, and that register 0 stays idle. It confirms that each issue of a writer marks its destination busy and each writeback clears its register. It also confirms that a branch issue raises the hold and that a resolution drops it. Other behaviour can only be shown by the bench's sequences: the stall counts of dependent add chains and of a load-use pair, the same-cycle writeback release, the destination conflict, and the source sets that each class ignores. The freeze window around two branches, one waiting on a busy operand, and reset during a pending branch are also shown only there.

// File: rtl/il_pkg.sv
package il_pkg;
    typedef enum logic [2:0] {
        CLS_ADD  = 3'd0,
        CLS_SUB  = 3'd1,
        CLS_ADDI = 3'd2,
        CLS_MUL  = 3'd3,
        CLS_LW   = 3'd4,
        CLS_SW   = 3'd5,
        CLS_BEQ  = 3'd6,
        CLS_NOP  = 3'd7
    } icls_e;

    typedef struct packed {
        logic reads_a;
        logic reads_b;
        logic writes;
        logic is_branch;
    } cls_use_t;

    function automatic cls_use_t cls_usage(input icls_e c);
        cls_use_t u;
        u = '0;
        unique case (c)
            CLS_ADD, CLS_SUB, CLS_MUL: begin
                u.reads_a = 1'b1; u.reads_b = 1'b1; u.writes = 1'b1;
            end
            CLS_ADDI, CLS_LW: begin
                u.reads_a = 1'b1; u.writes = 1'b1;
            end
            CLS_SW: begin
                u.reads_a = 1'b1; u.reads_b = 1'b1;
            end
            CLS_BEQ: begin
                u.reads_a = 1'b1; u.reads_b = 1'b1; u.is_branch = 1'b1;
            end
            default: u = '0;
        endcase
        return u;
    endfunction
endpackage

// File: rtl/il_class_decode.sv
module il_class_decode
    import il_pkg::*;
(
    input  logic [2:0] cls_i,
    input  logic       valid_i,
    output logic       reads_a_o,
    output logic       reads_b_o,
    output logic       writes_o,
    output logic       is_branch_o
);
    cls_use_t use_w;

    always_comb begin
        use_w       = cls_usage(icls_e'(cls_i));
        reads_a_o   = valid_i & use_w.reads_a;
        reads_b_o   = valid_i & use_w.reads_b;
        writes_o    = valid_i & use_w.writes;
        is_branch_o = valid_i & use_w.is_branch;
    end
endmodule

// File: rtl/il_conflict.sv
module il_conflict #(
    parameter int NREG = 32,
    parameter int RW   = $clog2(NREG)
) (
    input  logic [NREG-1:0] busy_i,
    input  logic            reads_a_i,
    input  logic [RW-1:0]   src_a_i,
    input  logic            reads_b_i,
    input  logic [RW-1:0]   src_b_i,
    input  logic            writes_i,
    input  logic [RW-1:0]   dst_i,
    input  logic            wb_valid_i,
    input  logic [RW-1:0]   wb_reg_i,
    output logic            conflict_o
);
    logic [NREG-1:0] pending;
    logic            hit_a;
    logic            hit_b;
    logic            hit_w;

    always_comb begin
        pending = busy_i;
        if (wb_valid_i) pending[wb_reg_i] = 1'b0;
        hit_a      = reads_a_i & pending[src_a_i];
        hit_b      = reads_b_i & pending[src_b_i];
        hit_w      = writes_i  & pending[dst_i];
        conflict_o = hit_a | hit_b | hit_w;
    end
endmodule

// File: rtl/il_scoreboard.sv
module il_scoreboard #(
    parameter int NREG = 32,
    parameter int RW   = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            set_en_i,
    input  logic [RW-1:0]   set_idx_i,
    input  logic            clr_en_i,
    input  logic [RW-1:0]   clr_idx_i,
    output logic [NREG-1:0] busy_o
);
    logic [NREG-1:0] busy_d;
    logic [NREG-1:0] busy_q;

    for (genvar g = 0; g < NREG; g++) begin : g_bit
        if (g == 0) begin : g_zero
            always_comb busy_d[g] = 1'b0;
        end else begin : g_live
            always_comb begin
                busy_d[g] = busy_q[g];
                if (clr_en_i && clr_idx_i == RW'(g)) busy_d[g] = 1'b0;
                if (set_en_i && set_idx_i == RW'(g)) busy_d[g] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) busy_q <= '0;
        else        busy_q <= busy_d;
    end

    assign busy_o = busy_q;
endmodule

// File: rtl/dec_interlock.sv
module dec_interlock #(
    parameter int NREG = 32,
    parameter int RW   = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            dec_valid,
    input  logic [2:0]      dec_cls,
    input  logic [RW-1:0]   dec_rs,
    input  logic [RW-1:0]   dec_rt,
    input  logic [RW-1:0]   dec_dst,
    input  logic            idex_empty,
    input  logic            wb_valid,
    input  logic [RW-1:0]   wb_reg,
    input  logic            br_resolved,
    output logic            issue,
    output logic            data_stall,
    output logic            br_hold,
    output logic            fetch_freeze,
    output logic            dec_hold,
    output logic [NREG-1:0] busy_vec
);
    typedef struct packed {
        logic br_pend;
    } ctl_t;

    ctl_t ctl_d;
    ctl_t ctl_q;

    logic reads_a, reads_b, writes, is_branch;
    logic conflict;
    logic issue_w;
    logic set_en;
    logic clr_en;

    il_class_decode u_cls (
        .cls_i       (dec_cls),
        .valid_i     (dec_valid),
        .reads_a_o   (reads_a),
        .reads_b_o   (reads_b),
        .writes_o    (writes),
        .is_branch_o (is_branch)
    );

    il_conflict #(.NREG(NREG), .RW(RW)) u_conf (
        .busy_i     (busy_vec),
        .reads_a_i  (reads_a),
        .src_a_i    (dec_rs),
        .reads_b_i  (reads_b),
        .src_b_i    (dec_rt),
        .writes_i   (writes),
        .dst_i      (dec_dst),
        .wb_valid_i (wb_valid),
        .wb_reg_i   (wb_reg),
        .conflict_o (conflict)
    );

    il_scoreboard #(.NREG(NREG), .RW(RW)) u_sb (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_en_i  (set_en),
        .set_idx_i (dec_dst),
        .clr_en_i  (clr_en),
        .clr_idx_i (wb_reg),
        .busy_o    (busy_vec)
    );

    always_comb begin
        issue_w = dec_valid & ~ctl_q.br_pend & idex_empty & ~conflict;
        set_en  = issue_w & writes & (dec_dst != '0);
        clr_en  = wb_valid & (wb_reg != '0);

        ctl_d = ctl_q;
        if (issue_w && is_branch) ctl_d.br_pend = 1'b1;
        else if (br_resolved)     ctl_d.br_pend = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign issue        = issue_w;
    assign data_stall   = dec_valid & ~ctl_q.br_pend & conflict;
    assign br_hold      = ctl_q.br_pend;
    assign fetch_freeze = ctl_q.br_pend | is_branch;
    assign dec_hold     = ctl_q.br_pend | (dec_valid & ~issue_w);
endmodule

// File: rtl/dec_interlock_chk.sv
module dec_interlock_chk #(
    parameter int NREG = 32,
    parameter int RW   = $clog2(NREG)
) (
    input logic            clk,
    input logic            rst_n,
    input logic            dec_valid,
    input logic [2:0]      dec_cls,
    input logic [RW-1:0]   dec_rs,
    input logic [RW-1:0]   dec_rt,
    input logic [RW-1:0]   dec_dst,
    input logic            idex_empty,
    input logic            wb_valid,
    input logic [RW-1:0]   wb_reg,
    input logic            br_resolved,
    input logic            issue,
    input logic            data_stall,
    input logic            br_hold,
    input logic            fetch_freeze,
    input logic            dec_hold,
    input logic [NREG-1:0] busy_vec
);
    logic wr_issue;
    assign wr_issue = issue && (dec_cls <= 3'd4) && (dec_dst != '0);

    AST_ISSUE_NEEDS_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
        issue |-> idex_empty); // R3
    AST_STALL_BLOCKS_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
        data_stall |-> !issue); // R5
    AST_REG0_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_vec[0]); // R8
    AST_DST_MARKED: assert property (@(posedge clk) disable iff (!rst_n)
        wr_issue |=> busy_vec[$past(dec_dst)]); // R7
    AST_WB_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_valid && wb_reg != '0 && !(wr_issue && dec_dst == wb_reg))
        |=> !busy_vec[$past(wb_reg)]); // R7
    AST_BEQ_RAISES_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && dec_cls == 3'd6) |=> br_hold); // R10
    AST_HOLD_NO_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
        br_hold |-> !issue); // R10
    AST_RESOLVE_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        (br_hold && br_resolved) |=> !br_hold); // R10
    AST_HOLD_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
        br_hold |-> (fetch_freeze && dec_hold)); // R11
endmodule

bind dec_interlock dec_interlock_chk #(.NREG(NREG), .RW(RW)) u_chk (.*);

// File: tb/dec_interlock_bench.sv
`timescale 1ns/1ps
module dec_interlock_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        dec_valid;
    logic [2:0]  dec_cls;
    logic [4:0]  dec_rs, dec_rt, dec_dst;
    logic        idex_empty;
    logic        wb_valid;
    logic [4:0]  wb_reg;
    logic        br_resolved;
    logic        issue, data_stall, br_hold, fetch_freeze, dec_hold;
    logic [31:0] busy_vec;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    dec_interlock u_dec_interlock (.*);

    // row: valid, cls, rs, rt, dst, empty, wbv, wbr, resolved, exp{issue,stall,hold,freeze,dhold}
    localparam int NV = 31;
    localparam logic [31:0] VEC [0:NV-1] = '{
        {1'b1,3'd0,5'd1,5'd2,5'd3,  1'b1,1'b0,5'd0, 1'b0,5'b10000}, // 0 add r3  R2
        {1'b1,3'd0,5'd3,5'd1,5'd4,  1'b1,1'b0,5'd0, 1'b0,5'b01001}, // 1 add r4<-r3 R5
        {1'b1,3'd0,5'd3,5'd1,5'd4,  1'b1,1'b0,5'd0, 1'b0,5'b01001}, // 2 R5
        {1'b1,3'd0,5'd3,5'd1,5'd4,  1'b1,1'b1,5'd3, 1'b0,5'b10000}, // 3 wb r3 R6
        {1'b1,3'd0,5'd4,5'd4,5'd5,  1'b1,1'b0,5'd0, 1'b0,5'b01001}, // 4 R5
        {1'b1,3'd0,5'd4,5'd4,5'd5,  1'b1,1'b1,5'd4, 1'b0,5'b10000}, // 5 R6
        {1'b1,3'd4,5'd7,5'd0,5'd6,  1'b1,1'b0,5'd0, 1'b0,5'b10000}, // 6 lw r6 R2
        {1'b1,3'd0,5'd6,5'd0,5'd8,  1'b1,1'b0,5'd0, 1'b0,5'b01001}, // 7 load-use R5
        {1'b1,3'd0,5'd6,5'd0,5'd8,  1'b1,1'b1,5'd5, 1'b0,5'b01001}, // 8 other wb R5
        {1'b1,3'd0,5'd6,5'd0,5'd8,  1'b1,1'b1,5'd6, 1'b0,5'b10000}, // 9 R6
        {1'b1,3'd2,5'd1,5'd8,5'd9,  1'b1,1'b0,5'd0, 1'b0,5'b10000}, // 10 addi ignores rt R4
        {1'b1,3'd5,5'd2,5'd9,5'd9,  1'b1,1'b0,5'd0, 1'b0,5'b01001}, // 11 sw data busy R4
        {1'b1,3'd5,5'd2,5'd9,5'd9,  1'b0,1'b1,5'd9, 1'b0,5'b00001}, // 12 latch full R3
        {1'b1,3'd5,5'd2,5'd9,5'd9,  1'b1,1'b0,5'd0, 1'b0,5'b10000}, // 13 R3
        {1'b1,3'd0,5'd9,5'd0,5'd10, 1'b1,1'b0,5'd0, 1'b0,5'b10000}, // 14 sw marked nothing R4
        {1'b1,3'd0,5'd0,5'd0,5'd0,  1'b1,1'b0,5'd0, 1'b0,5'b10000}, // 15 write r0 R8
        {1'b1,3'd0,5'd0,5'd0,5'd11, 1'b1,1'b0,5'd0, 1'b0,5'b10000}, // 16 read r0 R8
        {1'b1,3'd2,5'd1,5'd0,5'd8,  1'b1,1'b0,5'd0, 1'b0,5'b01001}, // 17 dst busy R9
        {1'b1,3'd2,5'd1,5'd0,5'd8,  1'b1,1'b1,5'd8, 1'b0,5'b10000}, // 18 R9
        {1'b1,3'd0,5'd8,5'd0,5'd12, 1'b1,1'b0,5'd0, 1'b0,5'b01001}, // 19 set wins R7
        {1'b1,3'd0,5'd8,5'd0,5'd12, 1'b1,1'b1,5'd8, 1'b0,5'b10000}, // 20 R7
        {1'b1,3'd6,5'd1,5'd2,5'd0,  1'b1,1'b0,5'd0, 1'b0,5'b10010}, // 21 beq R11
        {1'b1,3'd0,5'd1,5'd1,5'd13, 1'b1,1'b0,5'd0, 1'b0,5'b00111}, // 22 R10
        {1'b1,3'd0,5'd1,5'd1,5'd13, 1'b1,1'b0,5'd0, 1'b1,5'b00111}, // 23 resolve R10
        {1'b1,3'd0,5'd1,5'd1,5'd13, 1'b1,1'b0,5'd0, 1'b0,5'b10000}, // 24 R10
        {1'b1,3'd6,5'd10,5'd1,5'd0, 1'b1,1'b0,5'd0, 1'b0,5'b01011}, // 25 beq waits R11
        {1'b1,3'd6,5'd10,5'd1,5'd0, 1'b1,1'b1,5'd10,1'b0,5'b10010}, // 26 R11
        {1'b0,3'd0,5'd0,5'd0,5'd0,  1'b1,1'b0,5'd0, 1'b0,5'b00111}, // 27 R11
        {1'b0,3'd0,5'd0,5'd0,5'd0,  1'b1,1'b0,5'd0, 1'b1,5'b00111}, // 28 R10
        {1'b0,3'd0,5'd0,5'd0,5'd0,  1'b1,1'b0,5'd0, 1'b0,5'b00000}, // 29 R10
        {1'b1,3'd7,5'd11,5'd11,5'd12,1'b1,1'b0,5'd0,1'b0,5'b10000}  // 30 no-op R4
    };

    function automatic string row_req(input int i);
        if (i == 0 || i == 6)         return "R2";
        if (i == 3 || i == 5 || i == 9) return "R6";
        if (i < 10)                   return "R5";
        if (i == 12 || i == 13)       return "R3";
        if (i == 10 || i == 11 || i == 14 || i == 30) return "R4";
        if (i == 15 || i == 16)       return "R8";
        if (i == 17 || i == 18)       return "R9";
        if (i == 19 || i == 20)       return "R7";
        if (i == 21 || i == 25 || i == 26 || i == 27) return "R11";
        return "R10";
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        dec_valid = 0; dec_cls = 0; dec_rs = 0; dec_rt = 0; dec_dst = 0;
        idex_empty = 1; wb_valid = 0; wb_reg = 0; br_resolved = 0;
    endtask

    function automatic logic [31:0] outs();
        return {27'd0, issue, data_stall, br_hold, fetch_freeze, dec_hold};
    endfunction

    initial begin
        #(200000 * 5);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        idle_inputs();
        rst_n = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        #1;
        check("R1", busy_vec, 32'd0);
        check("R1", {31'd0, br_hold}, 32'd0);

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            {dec_valid, dec_cls, dec_rs, dec_rt, dec_dst,
             idex_empty, wb_valid, wb_reg, br_resolved} = VEC[i][31:5];
            #1;
            check(row_req(i), outs(), {27'd0, VEC[i][4:0]});
        end

        @(negedge clk);
        idle_inputs();
        #1;
        check("R7", busy_vec, 32'h0000_3800); // r11, r12, r13 pending

        // beq issues, then reset arrives while the branch is pending
        @(negedge clk);
        dec_valid = 1; dec_cls = 3'd6; dec_rs = 5'd1; dec_rt = 5'd2;
        @(negedge clk);
        idle_inputs();
        #1;
        check("R10", {31'd0, br_hold}, 32'd1);
        rst_n = 0;
        @(negedge clk);
        rst_n = 1;
        #1;
        check("R1", {31'd0, br_hold}, 32'd0);
        check("R1", busy_vec, 32'd0);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule